// File: doc/BRIEF.md
# Memory-mapped user IO controller

This block sits between a simple word-addressed register bus and the indicators and inputs of a board. It drives two seven-segment displays (each with a decimal point), four red LEDs, four green LEDs and four status LEDs, and it lets software read three push buttons and a four-position DIP switch.

Every output bit has two possible sources: a software register bit written over the bus, or a matching hardware input port. A control register picks the source bit by bit, so hardware can own the status LEDs (for example, to show live link activity) while software owns everything else. Each display has its own mode. In decode mode a 4-bit value is turned into a hex glyph. In raw mode seven stored bits drive the segments directly. The decimal point bit bypasses the mode in both cases. The button and switch inputs pass through a synchronizer before software can read them.

Bus accesses are single-cycle. A write takes effect at the clock edge on which `reg_we` is high. Read data is a combinational function of `reg_addr` and the stored state.

Top module: `uio_ctrl`

## Requirements
- R1: While reset is held and after it is released, the control register reads 0x0F000000 and every software register reads 0. The status LEDs follow `hw_led_stat`. Every other segment and LED output is 0.
- R2: The control register at word index 0 stores bits 29:0 and reads back the stored value. Its fields are:
  - bit 29: hex decode for the left display
  - bit 28: hex decode for the right display
  - bits 27:24: source select for the status LEDs (same bit order as `led_stat`)
  - bits 23:20: source select for the green LEDs
  - bits 19:16: source select for the red LEDs
  - bits 15:8: source select for the left segments
  - bits 7:0: source select for the right segments

  A write to any other index leaves the control register unchanged.
- R3: For every output bit, a source-select value of 1 drives the pin from the matching `hw_*` port bit. A value of 0 drives the pin from the software register bit.
- R4: In hex decode mode, bits 3:0 of a display register (left at index 1, right at index 2) are shown as the glyphs 0-9, A, b, C, d, E, F. Bits 6:4 are ignored. Segment outputs are ordered {a,b,c,d,e,f,g,dp} from bit 7 down to bit 0, and are active high.
- R5: In raw mode, bits 6:0 of a display register drive segments a through g directly, with bit 6 driving segment a.
- R6: Bit 8 of a display register drives that display's decimal point (segment output bit 0) in both modes.
- R7: The LED registers each hold 4 bits, active high, with bit 0 driving output bit 0:
  - red LEDs: index 3
  - green LEDs: index 4
  - status LEDs: index 5, where bit 0 is A green, bit 1 A red, bit 2 B green and bit 3 B red
- R8: Index 6 is read-only and holds the synchronized inputs:
  - bit 6: up button
  - bit 5: middle button
  - bit 4: down button
  - bits 3:0: DIP switch

  A change on an input becomes readable exactly SYNC_STAGES rising edges later. Writes to index 6 have no effect.
- R9: Reading an output register returns the stored software value, even when the pins of that output are under hardware control.
- R10: Reserved bits read as 0. Addresses above 6 read as 0. Writes to reserved bits or to unmapped addresses change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Word index of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| hw_seg_l | input | 8 | Hardware source for the left segments {a..g,dp} |
| hw_seg_r | input | 8 | Hardware source for the right segments {a..g,dp} |
| hw_led_red | input | 4 | Hardware source for the red LEDs |
| hw_led_grn | input | 4 | Hardware source for the green LEDs |
| hw_led_stat | input | 4 | Hardware source for the status LEDs |
| btn_up | input | 1 | Up push button |
| btn_mid | input | 1 | Middle push button |
| btn_dn | input | 1 | Down push button |
| dip_sw | input | 4 | DIP switch, bit 0 is the right-most position |
| seg_l | output | 8 | Left display segments {a,b,c,d,e,f,g,dp} |
| seg_r | output | 8 | Right display segments {a,b,c,d,e,f,g,dp} |
| led_red | output | 4 | Red LEDs |
| led_grn | output | 4 | Green LEDs |
| led_stat | output | 4 | Status LEDs {B red, B green, A red, A green} |

## Verification
The bench builds the block with ADDR_W=4 and SYNC_STAGES=3. The wider address reaches nine unmapped indices (7 to 15), so random writes and reads there show that those addresses decode to nothing. The deeper synchronizer makes the input latency check an exact count of three edges, which a single-stage off-by-one would miss. Random source-select masks mix hardware and software bits within the same output, and all sixteen digits are swept in decode mode with the ignored bits 6:4 set.

// File: rtl/uio_pkg.sv
package uio_pkg;
   localparam int unsigned IDX_CTRL = 0;
   localparam int unsigned IDX_DISP_L = 1;
   localparam int unsigned IDX_DISP_R = 2;
   localparam int unsigned IDX_RED = 3;
   localparam int unsigned IDX_GRN = 4;
   localparam int unsigned IDX_STAT = 5;
   localparam int unsigned IDX_INPUT = 6;

   localparam int unsigned CTRL_W = 30;
   localparam int unsigned DISP_W = 9;
   localparam int unsigned LED_N = 4;
   localparam int unsigned SEG_N = 8;
   localparam int unsigned IN_W = 7;

   localparam logic [CTRL_W-1:0] CTRL_RESET = 30'h0F00_0000;

   localparam int unsigned BIT_HEX_L = 29;
   localparam int unsigned BIT_HEX_R = 28;
endpackage

// File: rtl/uio_sync.sv
module uio_sync #(
   parameter int unsigned W = 7,
   parameter int unsigned STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("uio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/uio_src_mux.sv
module uio_src_mux #(
   parameter int unsigned W = 4
) (
   input logic [W-1:0] sel_hw,
   input logic [W-1:0] sw_val,
   input logic [W-1:0] hw_val,
   output logic [W-1:0] pin
);
   if (W < 1) begin : g_bad_w
      $error("uio_src_mux: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign pin[i] = sel_hw[i] ? hw_val[i] : sw_val[i];
   end
endmodule

// File: rtl/uio_disp_path.sv
module uio_disp_path (
   input logic hex_mode,
   input logic [8:0] data,
   output logic [7:0] seg_sw
);
   logic [6:0] glyph;

   always_comb begin
      case (data[3:0])
         4'h0: glyph = 7'h7E;
         4'h1: glyph = 7'h30;
         4'h2: glyph = 7'h6D;
         4'h3: glyph = 7'h79;
         4'h4: glyph = 7'h33;
         4'h5: glyph = 7'h5B;
         4'h6: glyph = 7'h5F;
         4'h7: glyph = 7'h70;
         4'h8: glyph = 7'h7F;
         4'h9: glyph = 7'h7B;
         4'hA: glyph = 7'h77;
         4'hB: glyph = 7'h1F;
         4'hC: glyph = 7'h4E;
         4'hD: glyph = 7'h3D;
         4'hE: glyph = 7'h4F;
         default: glyph = 7'h47;
      endcase
   end

   // R4: every glyph lights at least two segments
   always_comb begin
      assert_glyph_lit_R4: assert ($countones(glyph) >= 2);
   end

   assign seg_sw = {(hex_mode ? glyph : data[6:0]), data[8]};
endmodule

// File: rtl/uio_ctrl.sv
module uio_ctrl
   import uio_pkg::*;
#(
   parameter int unsigned DW = 32,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic reg_we,
   input logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input logic [7:0] hw_seg_l,
   input logic [7:0] hw_seg_r,
   input logic [3:0] hw_led_red,
   input logic [3:0] hw_led_grn,
   input logic [3:0] hw_led_stat,
   input logic btn_up,
   input logic btn_mid,
   input logic btn_dn,
   input logic [3:0] dip_sw,
   output logic [7:0] seg_l,
   output logic [7:0] seg_r,
   output logic [3:0] led_red,
   output logic [3:0] led_grn,
   output logic [3:0] led_stat
);
   if (DW < 32) begin : g_bad_dw
      $error("uio_ctrl: DW must be at least 32");
   end
   if (ADDR_W < 3) begin : g_bad_aw
      $error("uio_ctrl: ADDR_W must be at least 3");
   end

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(IDX_CTRL);
   localparam logic [ADDR_W-1:0] A_DL = ADDR_W'(IDX_DISP_L);
   localparam logic [ADDR_W-1:0] A_DR = ADDR_W'(IDX_DISP_R);
   localparam logic [ADDR_W-1:0] A_RED = ADDR_W'(IDX_RED);
   localparam logic [ADDR_W-1:0] A_GRN = ADDR_W'(IDX_GRN);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(IDX_STAT);
   localparam logic [ADDR_W-1:0] A_IN = ADDR_W'(IDX_INPUT);

   logic [CTRL_W-1:0] ctrl_q;
   logic [DISP_W-1:0] dl_q, dr_q;
   logic [LED_N-1:0] red_q, grn_q, stat_q;
   logic [IN_W-1:0] in_sync;
   logic [SEG_N-1:0] segl_sw, segr_sw;

   // register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
         dl_q <= '0;
         dr_q <= '0;
         red_q <= '0;
         grn_q <= '0;
         stat_q <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            A_CTRL: ctrl_q <= reg_wdata[CTRL_W-1:0];
            A_DL: dl_q <= reg_wdata[DISP_W-1:0];
            A_DR: dr_q <= reg_wdata[DISP_W-1:0];
            A_RED: red_q <= reg_wdata[LED_N-1:0];
            A_GRN: grn_q <= reg_wdata[LED_N-1:0];
            A_STAT: stat_q <= reg_wdata[LED_N-1:0];
            default: ;
         endcase
      end
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
         A_DL: reg_rdata[DISP_W-1:0] = dl_q;
         A_DR: reg_rdata[DISP_W-1:0] = dr_q;
         A_RED: reg_rdata[LED_N-1:0] = red_q;
         A_GRN: reg_rdata[LED_N-1:0] = grn_q;
         A_STAT: reg_rdata[LED_N-1:0] = stat_q;
         A_IN: reg_rdata[IN_W-1:0] = in_sync;
         default: reg_rdata = '0;
      endcase
   end

   uio_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk),
      .rst_n(rst_n),
      .d({btn_up, btn_mid, btn_dn, dip_sw}),
      .q(in_sync)
   );

   uio_disp_path u_disp_l (
      .hex_mode(ctrl_q[BIT_HEX_L]),
      .data(dl_q),
      .seg_sw(segl_sw)
   );
   uio_disp_path u_disp_r (
      .hex_mode(ctrl_q[BIT_HEX_R]),
      .data(dr_q),
      .seg_sw(segr_sw)
   );

   uio_src_mux #(.W(SEG_N)) u_mux_segl (
      .sel_hw(ctrl_q[15:8]), .sw_val(segl_sw), .hw_val(hw_seg_l), .pin(seg_l)
   );
   uio_src_mux #(.W(SEG_N)) u_mux_segr (
      .sel_hw(ctrl_q[7:0]), .sw_val(segr_sw), .hw_val(hw_seg_r), .pin(seg_r)
   );
   uio_src_mux #(.W(LED_N)) u_mux_red (
      .sel_hw(ctrl_q[19:16]), .sw_val(red_q), .hw_val(hw_led_red), .pin(led_red)
   );
   uio_src_mux #(.W(LED_N)) u_mux_grn (
      .sel_hw(ctrl_q[23:20]), .sw_val(grn_q), .hw_val(hw_led_grn), .pin(led_grn)
   );
   uio_src_mux #(.W(LED_N)) u_mux_stat (
      .sel_hw(ctrl_q[27:24]), .sw_val(stat_q), .hw_val(hw_led_stat), .pin(led_stat)
   );

   // assertions
   assert_red_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_RED && ctrl_q[19:16] == 4'h0)
      |=> (led_red == $past(reg_wdata[3:0])));

   assert_stat_hw_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[27:24] == 4'hF) |-> (led_stat == hw_led_stat));

   assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == A_CTRL) |=> $stable(ctrl_q));

   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr > A_IN) |-> (reg_rdata == '0));

   assert_input_rsv_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_IN) |-> (reg_rdata[DW-1:IN_W] == '0));
endmodule

// File: tb/tb_uio_ctrl.sv
module tb_uio_ctrl;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 4;
   localparam int unsigned NS = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic reg_we = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [7:0] hw_seg_l = '0, hw_seg_r = '0;
   logic [3:0] hw_led_red = '0, hw_led_grn = '0, hw_led_stat = '0;
   logic btn_up = 1'b0, btn_mid = 1'b0, btn_dn = 1'b0;
   logic [3:0] dip_sw = '0;
   logic [7:0] seg_l, seg_r;
   logic [3:0] led_red, led_grn, led_stat;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // shadow model of the software-visible state
   logic [29:0] s_ctrl = 30'h0F00_0000;
   logic [8:0] s_dl = '0, s_dr = '0;
   logic [3:0] s_red = '0, s_grn = '0, s_stat = '0;

   always #2 clk = ~clk;

   uio_ctrl #(.DW(DW), .ADDR_W(AW), .SYNC_STAGES(NS)) dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .hw_seg_l(hw_seg_l), .hw_seg_r(hw_seg_r), .hw_led_red(hw_led_red),
      .hw_led_grn(hw_led_grn), .hw_led_stat(hw_led_stat),
      .btn_up(btn_up), .btn_mid(btn_mid), .btn_dn(btn_dn), .dip_sw(dip_sw),
      .seg_l(seg_l), .seg_r(seg_r), .led_red(led_red), .led_grn(led_grn),
      .led_stat(led_stat)
   );

   function automatic logic [6:0] hex7(input logic [3:0] d);
      case (d)
         4'h0: return 7'b1111110;
         4'h1: return 7'b0110000;
         4'h2: return 7'b1101101;
         4'h3: return 7'b1111001;
         4'h4: return 7'b0110011;
         4'h5: return 7'b1011011;
         4'h6: return 7'b1011111;
         4'h7: return 7'b1110000;
         4'h8: return 7'b1111111;
         4'h9: return 7'b1111011;
         4'hA: return 7'b1110111;
         4'hB: return 7'b0011111;
         4'hC: return 7'b1001110;
         4'hD: return 7'b0111101;
         4'hE: return 7'b1001111;
         default: return 7'b1000111;
      endcase
   endfunction

   function automatic logic [7:0] sw_seg(input logic mode, input logic [8:0] d);
      return {(mode ? hex7(d[3:0]) : d[6:0]), d[8]};
   endfunction

   function automatic logic [31:0] pick(input logic [31:0] sel, input logic [31:0] sw,
                                        input logic [31:0] hw);
      return (sel & hw) | (~sel & sw);
   endfunction

   function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
      case (a)
         4'd0: return {2'b00, s_ctrl};
         4'd1: return {23'd0, s_dl};
         4'd2: return {23'd0, s_dr};
         4'd3: return {28'd0, s_red};
         4'd4: return {28'd0, s_grn};
         4'd5: return {28'd0, s_stat};
         4'd6: return {25'd0, btn_up, btn_mid, btn_dn, dip_sw};
         default: return 32'd0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_outputs(input string req);
      #1;
      chk({req, " seg_l"}, {24'd0, seg_l},
          pick({24'd0, s_ctrl[15:8]}, {24'd0, sw_seg(s_ctrl[29], s_dl)}, {24'd0, hw_seg_l}));
      chk({req, " seg_r"}, {24'd0, seg_r},
          pick({24'd0, s_ctrl[7:0]}, {24'd0, sw_seg(s_ctrl[28], s_dr)}, {24'd0, hw_seg_r}));
      chk({req, " led_red"}, {28'd0, led_red},
          pick({28'd0, s_ctrl[19:16]}, {28'd0, s_red}, {28'd0, hw_led_red}));
      chk({req, " led_grn"}, {28'd0, led_grn},
          pick({28'd0, s_ctrl[23:20]}, {28'd0, s_grn}, {28'd0, hw_led_grn}));
      chk({req, " led_stat"}, {28'd0, led_stat},
          pick({28'd0, s_ctrl[27:24]}, {28'd0, s_stat}, {28'd0, hw_led_stat}));
   endtask

   task automatic rd(input string req, input logic [AW-1:0] a);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp_read(a));
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      reg_wdata = d;
      reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      case (a)
         4'd0: s_ctrl = d[29:0];
         4'd1: s_dl = d[8:0];
         4'd2: s_dr = d[8:0];
         4'd3: s_red = d[3:0];
         4'd4: s_grn = d[3:0];
         4'd5: s_stat = d[3:0];
         default: ;
      endcase
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      hw_led_stat = 4'b1010;
      repeat (3) @(negedge clk);
      check_outputs("R1 in reset");
      rst_n = 1'b1;
      for (int a = 0; a < 7; a++) rd("R1 reset readback", AW'(a));
      check_outputs("R1 after reset");

      // R2: control storage and reserved bits
      wr(0, 32'hFFFF_FFFF);
      rd("R2 ctrl readback", 0);
      check_outputs("R2/R3 all hw");
      wr(3, 32'h5);
      rd("R2 ctrl unchanged by other write", 0);

      // R4: hex decode on left, bits 6:4 set to prove they are ignored
      wr(0, 32'h2000_0000);
      for (int d = 0; d < 16; d++) begin
         wr(1, 32'h70 | 32'(d));
         check_outputs("R4 left hex sweep");
      end
      // R4 right display decode and R6 dp in hex mode
      wr(0, 32'h1000_0000);
      wr(2, 32'h10B);
      #1 chk("R4/R6 right hex b with dp", {24'd0, seg_r}, {24'd0, 7'b0011111, 1'b1});

      // R5/R6 raw mode
      wr(0, 32'h0);
      wr(1, 32'h155);
      #1 chk("R5/R6 raw left", {24'd0, seg_l}, 32'h0000_00AB);

      // R7 LED mapping
      wr(3, 32'h1);
      #1 chk("R7 red bit0 lowest", {28'd0, led_red}, 32'h1);
      wr(4, 32'h8);
      #1 chk("R7 green bit3", {28'd0, led_grn}, 32'h8);
      wr(5, 32'h2);
      #1 chk("R7 status A red", {28'd0, led_stat}, 32'h2);

      // R9 readback not pin state
      wr(0, 32'h000F_0000);
      hw_led_red = 4'hF;
      wr(3, 32'h5);
      #1 chk("R9 red pin follows hw", {28'd0, led_red}, 32'hF);
      rd("R9 red reads stored value", 3);

      // R8 synchronizer latency
      @(negedge clk);
      reg_addr = 4'd6;
      btn_up = 1'b1;
      dip_sw = 4'hA;
      repeat (NS - 1) @(negedge clk);
      #1 chk("R8 input not yet visible", reg_rdata, 32'h0);
      @(negedge clk);
      #1 chk("R8 input visible after stages", reg_rdata, 32'h4A);
      wr(6, 32'h7F);
      rd("R8 write to input ignored", 6);
      check_outputs("R8 write to input no output effect");

      // R10 unmapped addresses
      wr(9, 32'hFFFF_FFFF);
      rd("R10 unmapped read zero", 9);
      for (int a = 0; a < 7; a++) rd("R10 state unchanged", AW'(a));
      check_outputs("R10 unmapped write no effect");

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         hw_seg_l = 8'($urandom);
         hw_seg_r = 8'($urandom);
         hw_led_red = 4'($urandom);
         hw_led_grn = 4'($urandom);
         hw_led_stat = 4'($urandom);
         wr(AW'($urandom), $urandom);
         check_outputs("R3 random");
         rd("R9/R10 random read", AW'($urandom));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule